// File: doc/BRIEF.md
# Startup Phase Sequencer with Clock-Lock Stall

This block walks a device through its power-up phases after configuration. On every startup clock a phase counter moves one step through a fixed run of phases. Three outputs rise at set points in that run and then stay high: release of the global output tristate, the global write enable, and the final done flag. Once the counter reaches the last phase it stays there until reset.

The sequence can be made to wait for attached clock generators. Each generator supplies a lock flag, which is passed through a two-flop synchronizer inside the block. The integrator can pick one phase as a stall point, and can also mark individual generators as ones the sequence must wait for. If some generators are marked, the stall waits for exactly those. If none is marked but a stall phase is chosen, the stall waits for every generator. If a generator is marked and no stall phase is chosen, the sequence stalls in the phase just ahead of done. Generators cannot lock while outputs are tristated, so the tristate is released no later than the moment the counter reaches the stall phase. The lock flags are only read by the block and are never changed by it.

Top module: `startup_seq`

## Requirements
- R1: While rst_ni is low, phase_o is 0 and done_o, gwe_o and tri_rel_o are 0.
- R2: When no stall applies, phase_o increases by exactly one at each rising clk_i edge. On reaching the last phase (all ones, 7 with PHASE_W=3) it stays there.
- R3: gwe_o becomes 1 at the edge where phase_o enters GWE_PHASE (5), and done_o at the edge where it enters DONE_PHASE (6). Both then stay 1 until reset, even if lock flags later fall.
- R4: When wait_mask_i is all zeros and lock_en_i is 0, the sequence never stalls, whatever lock_i, lock_sel_i and hiz_early_i hold.
- R5: When wait_mask_i is nonzero and lock_en_i is 0, the counter holds at phase DONE_PHASE-1 (5) until every generator whose wait_mask_i bit is 1 shows a synchronized lock of 1.
- R6: When lock_en_i is 1, the counter holds at phase lock_sel_i. It waits for the generators marked in wait_mask_i, or for all NUM_GEN generators if wait_mask_i is all zeros.
- R7: lock_i is used only through two register stages. A stall is released at the second rising edge after the edge that first samples the completing lock value.
- R8: tri_rel_o becomes 1 at the first edge after which phase_o is at least HIZ_PHASE (3). With hiz_early_i=1 it is instead at least 1. When a stall is configured (R5 or R6), it is also at least the stall phase. Once 1, tri_rel_o stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Startup clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_i | input | NUM_GEN | Lock flag from each clock generator, asynchronous |
| wait_mask_i | input | NUM_GEN | Generators the sequence must wait for |
| lock_en_i | input | 1 | Enables the stall at the phase given by lock_sel_i |
| lock_sel_i | input | PHASE_W | Phase index at which the sequence stalls |
| hiz_early_i | input | 1 | Releases the tristate on the first phase step |
| phase_o | output | PHASE_W | Current phase index |
| done_o | output | 1 | Startup complete, sticky |
| gwe_o | output | 1 | Global write enable, sticky |
| tri_rel_o | output | 1 | Global tristate released, sticky |

## Verification
The bench sweeps every combination of early release, stall enable, stall phase and wait mask on a three-generator build, and runs each combination under two lock patterns. In the first pattern the generators lock one at a time and then all drop together. Because of this, a stall released on any single lock (an OR of the flags, not an AND) is caught, and so is a done flag that falls when lock is lost. In the second pattern all generators are locked from the start, which isolates the two-edge synchronizer delay, including a stall at phase 0. Sweeping the stall phase past the done and last phases shows where the stall sits relative to the points where the sticky outputs rise. The configurations with an empty mask and no stall enable check that lock flags are ignored.

// File: rtl/startup_pkg.sv
package startup_pkg;

    // Which set of lock flags the stall waits on
    typedef enum logic [1:0] {
        WAIT_NONE   = 2'd0,
        WAIT_MASKED = 2'd1,
        WAIT_ALL    = 2'd2
    } wait_mode_e;

endpackage

// File: rtl/startup_lock_sync.sv
module startup_lock_sync #(
    parameter int unsigned WIDTH = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    // Two register stages per lock flag
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q;
        logic stable_q;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta_q   <= async_i[g];
                stable_q <= meta_q;
            end
        end

        assign sync_o[g] = stable_q;
    end

endmodule

// File: rtl/startup_lock_gate.sv
module startup_lock_gate
    import startup_pkg::*;
#(
    parameter int unsigned NUM_GEN       = 3,
    parameter int unsigned PHASE_W       = 3,
    parameter int unsigned DEFAULT_STALL = 5
) (
    input  logic [NUM_GEN-1:0] lock_sync_i,
    input  logic [NUM_GEN-1:0] wait_mask_i,
    input  logic               lock_en_i,
    input  logic [PHASE_W-1:0] lock_sel_i,
    input  logic [PHASE_W-1:0] phase_i,
    output wait_mode_e         mode_o,
    output logic [PHASE_W-1:0] stall_phase_o,
    output logic               hold_o
);

    logic [NUM_GEN-1:0] need;
    logic               all_ok;

    always_comb begin
        if (|wait_mask_i) begin
            mode_o = WAIT_MASKED;
            need   = wait_mask_i;
        end else if (lock_en_i) begin
            mode_o = WAIT_ALL;
            need   = {NUM_GEN{1'b1}};
        end else begin
            mode_o = WAIT_NONE;
            need   = '0;
        end

        stall_phase_o = lock_en_i ? lock_sel_i : PHASE_W'(DEFAULT_STALL);
        all_ok        = &(lock_sync_i | ~need);
        hold_o        = (mode_o != WAIT_NONE) && (phase_i == stall_phase_o) && !all_ok;
    end

endmodule

// File: rtl/startup_seq.sv
module startup_seq
    import startup_pkg::*;
#(
    parameter int unsigned NUM_GEN    = 3,
    parameter int unsigned PHASE_W    = 3,
    parameter int unsigned HIZ_PHASE  = 3,
    parameter int unsigned GWE_PHASE  = 5,
    parameter int unsigned DONE_PHASE = 6
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_GEN-1:0] lock_i,
    input  logic [NUM_GEN-1:0] wait_mask_i,
    input  logic               lock_en_i,
    input  logic [PHASE_W-1:0] lock_sel_i,
    input  logic               hiz_early_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               done_o,
    output logic               gwe_o,
    output logic               tri_rel_o
);

    localparam logic [PHASE_W-1:0] LAST_PHASE = {PHASE_W{1'b1}};
    localparam logic [PHASE_W-1:0] HIZ_P      = PHASE_W'(HIZ_PHASE);
    localparam logic [PHASE_W-1:0] GWE_P      = PHASE_W'(GWE_PHASE);
    localparam logic [PHASE_W-1:0] DONE_P     = PHASE_W'(DONE_PHASE);
    localparam int unsigned        STALL_DEF  = DONE_PHASE - 1;

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic               done;
        logic               gwe;
        logic               tri_rel;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [NUM_GEN-1:0] lock_sync;
    wait_mode_e         mode;
    logic [PHASE_W-1:0] stall_phase;
    logic               hold;

    startup_lock_sync #(
        .WIDTH (NUM_GEN)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (lock_i),
        .sync_o  (lock_sync)
    );

    startup_lock_gate #(
        .NUM_GEN       (NUM_GEN),
        .PHASE_W       (PHASE_W),
        .DEFAULT_STALL (STALL_DEF)
    ) u_gate (
        .lock_sync_i   (lock_sync),
        .wait_mask_i   (wait_mask_i),
        .lock_en_i     (lock_en_i),
        .lock_sel_i    (lock_sel_i),
        .phase_i       (st_q.phase),
        .mode_o        (mode),
        .stall_phase_o (stall_phase),
        .hold_o        (hold)
    );

    always_comb begin
        st_d = st_q;

        if (!hold && (st_q.phase != LAST_PHASE)) begin
            st_d.phase = st_q.phase + 1'b1;
        end

        st_d.gwe  = st_q.gwe  | (st_d.phase >= GWE_P);
        st_d.done = st_q.done | (st_d.phase >= DONE_P);

        // Tristate must be gone by the time a stall is reached
        st_d.tri_rel = st_q.tri_rel
                     | (st_d.phase >= HIZ_P)
                     | (hiz_early_i && (st_d.phase != '0))
                     | ((mode != WAIT_NONE) && (st_d.phase >= stall_phase));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o   = st_q.phase;
    assign done_o    = st_q.done;
    assign gwe_o     = st_q.gwe;
    assign tri_rel_o = st_q.tri_rel;

endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk #(
    parameter int unsigned PHASE_W = 3
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [PHASE_W-1:0] phase_o,
    input logic               done_o,
    input logic               gwe_o,
    input logic               tri_rel_o
);

    localparam logic [PHASE_W-1:0] LAST_PHASE = {PHASE_W{1'b1}};

    logic seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seen_q <= 1'b0;
        else         seen_q <= 1'b1;
    end

    // R3
    done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> done_o);

    // R3
    gwe_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> gwe_o);

    // R2
    phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o != LAST_PHASE) |=>
            ((phase_o == $past(phase_o)) || (phase_o == PHASE_W'($past(phase_o) + 1'b1))));

    // R2
    phase_last_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == LAST_PHASE) |=> (phase_o == LAST_PHASE));

    // R8
    tri_during_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && $stable(phase_o) && (phase_o != LAST_PHASE)) |-> tri_rel_o);

    // R8
    tri_before_gwe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gwe_o |-> tri_rel_o);

endmodule

bind startup_seq startup_seq_chk #(.PHASE_W(PHASE_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_o   (phase_o),
    .done_o    (done_o),
    .gwe_o     (gwe_o),
    .tri_rel_o (tri_rel_o)
);

// File: tb/tb_startup_seq.sv
module tb_startup_seq;

    localparam int NG = 3;
    localparam int PW = 3;
    localparam int RUN_LEN = 40;

    logic          clk_i = 1'b0;
    logic          rst_ni;
    logic [NG-1:0] lock_i;
    logic [NG-1:0] wait_mask_i;
    logic          lock_en_i;
    logic [PW-1:0] lock_sel_i;
    logic          hiz_early_i;
    logic [PW-1:0] phase_o;
    logic          done_o;
    logic          gwe_o;
    logic          tri_rel_o;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk_i = ~clk_i;

    startup_seq dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .lock_i      (lock_i),
        .wait_mask_i (wait_mask_i),
        .lock_en_i   (lock_en_i),
        .lock_sel_i  (lock_sel_i),
        .hiz_early_i (hiz_early_i),
        .phase_o     (phase_o),
        .done_o      (done_o),
        .gwe_o       (gwe_o),
        .tri_rel_o   (tri_rel_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (en=%0d sel=%0d mask=%0d early=%0d)",
                     tag, act, exp, lock_en_i, lock_sel_i, wait_mask_i, hiz_early_i);
        end
    endtask

    function automatic logic [NG-1:0] lock_for(input int t, input int pat);
        if (t >= 30) return '0;
        if (pat == 1) return '1;
        if (t < 10) return 3'b000;
        if (t < 14) return 3'b001;
        if (t < 18) return 3'b011;
        return 3'b111;
    endfunction

    // Watchdog
    always @(posedge clk_i) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst_ni      = 1'b0;
        lock_i      = '0;
        wait_mask_i = '0;
        lock_en_i   = 1'b0;
        lock_sel_i  = '0;
        hiz_early_i = 1'b0;

        for (int e = 0; e < 2; e++) begin
            for (int l = 0; l < 2; l++) begin
                for (int s = 0; s < 8; s++) begin
                    for (int m = 0; m < 8; m++) begin
                        for (int p = 0; p < 2; p++) begin
                            int ph, sp;
                            bit dn, gw, tr, act;
                            logic [NG-1:0] s1, s2, need;

                            @(negedge clk_i);
                            rst_ni      = 1'b0;
                            hiz_early_i = e[0];
                            lock_en_i   = l[0];
                            lock_sel_i  = PW'(s);
                            wait_mask_i = NG'(m);
                            lock_i      = '1;
                            @(negedge clk_i);
                            // R1: reset state, even with locks high
                            check(phase_o == 0, "R1 phase", phase_o, 0);
                            check({done_o, gwe_o, tri_rel_o} == 3'b000, "R1 flags",
                                  {done_o, gwe_o, tri_rel_o}, 0);
                            rst_ni = 1'b1;

                            ph = 0; dn = 0; gw = 0; tr = 0; s1 = '0; s2 = '0;
                            act  = (l != 0) || (m != 0);
                            sp   = (l != 0) ? s : 5;
                            need = (m != 0) ? NG'(m) : ((l != 0) ? '1 : '0);

                            for (int t = 0; t < RUN_LEN; t++) begin
                                logic [NG-1:0] lk;
                                bit stall;
                                lk = lock_for(t, p);
                                lock_i = lk;
                                @(posedge clk_i);
                                stall = act && (ph == sp) && ((s2 & need) != need);
                                if (!stall && ph != 7) ph = ph + 1;
                                s2 = s1;
                                s1 = lk;
                                gw = gw | (ph >= 5);
                                dn = dn | (ph >= 6);
                                tr = tr | (ph >= 3) | (e != 0 && ph >= 1) | (act && ph >= sp);
                                @(negedge clk_i);
                                // R2 R4 R5 R6 R7: phase trajectory
                                check(phase_o == PW'(ph), "R2 R4 R5 R6 R7 phase", phase_o, ph);
                                // R3: sticky enable and done
                                check(gwe_o == gw, "R3 gwe", gwe_o, gw);
                                check(done_o == dn, "R3 done", done_o, dn);
                                // R8: tristate release
                                check(tri_rel_o == tr, "R8 tri_rel", tri_rel_o, tr);
                            end
                        end
                    end
                end
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule